// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block translates a virtual address into a physical address by walking a tree of page-sized tables held in memory. The virtual page number is cut into equal index fields, one for each level of the tree, with level 0 taken from the most significant bits. The walk starts at the table page named by the directory frame input. At each level the block reads one 4-byte entry, checks that entry's valid flag, and uses the entry's frame number as the table page for the next level. The leaf entry's frame number is joined with the untranslated page offset to form the physical address.

A sparse tree needs table pages only where the address space is in use. An invalid entry at any level ends the walk at once with a fault that names the level, so unmapped regions cost one read and no table storage. The requester hands over one address at a time with a ready/valid pair and receives a one-cycle response pulse. Memory is reached through a read port with a single outstanding access.

The default build has a 14-bit virtual address, 64-byte pages and two levels with 4-bit indices, giving 16-entry tables. A deeper build has a 30-bit address, 512-byte pages and three levels with 7-bit indices. Level count, index width, offset width and physical address width are all parameters.

Top module: `tree_xlate_walker`

## Requirements
- R1: While reset is held and on the first cycles after it is released, `req_ready` is 1 and `rsp_valid` and `mem_rd_valid` are 0.
- R2: The first read of a walk goes to byte address `{dir_base, OFF_W zero bits} + 4*idx0`, where `dir_base` is sampled when the request is accepted.
- R3: Each later read goes to `{F, OFF_W zero bits} + 4*idx`, where F is the frame field of the entry read at the previous level and idx is the index for the current level.
- R4: An entry is 32 bits wide. Bit 31 is the valid flag and bits [FRAME_W-1:0] hold the frame number (FRAME_W = PA_W - OFF_W). Bits 30 down to FRAME_W have no effect on any read address or on the result.
- R5: When every entry on the path is valid, the response has `rsp_fault` = 0 and `rsp_pa` = `{leaf frame, va[OFF_W-1:0]}`.
- R6: When the entry read at level k is invalid, the walk stops. The response has `rsp_fault` = 1, `rsp_lvl` = k (0 = directory) and `rsp_pa` = 0.
- R7: A walk makes exactly one memory read per level it visits: LEVELS reads on success, and k+1 reads on a fault at level k.
- R8: At most one memory read is outstanding. `mem_rd_valid` stays low from an accepted read until its response arrives, and `mem_rd_addr` holds steady while a read waits for `mem_rd_ready`.
- R9: `req_ready` is low from acceptance until the response. `rsp_valid` is a single-cycle pulse per accepted request.
- R10: The index for level j is `va[OFF_W + (LEVELS-1-j)*IDX_W +: IDX_W]`. With the defaults, level 0 uses va[13:10] and level 1 uses va[9:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_base | input | PA_W-OFF_W | Frame number of the level-0 table page |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_va | input | LEVELS*IDX_W+OFF_W | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse carrying the result |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_lvl | output | max(1,clog2(LEVELS)) | Level of the invalid entry |
| rsp_pa | output | PA_W | Physical address; 0 on a fault |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |

## Verification
The bench builds random sparse trees in its own memory model. It uses random read latency and random `mem_rd_ready` gaps. It checks every read address and the read count against its own walk, which would expose an index taken from the wrong bits or a frame not shifted by the offset width. Directed walks cover a fault in the directory and a fault in the leaf, so a walker that kept reading after an invalid entry, reported the wrong level, or leaked a stale address would be caught. Entries with all the unused bits set catch a frame field that is too wide. Extreme indices and offsets (all zeros, all ones) catch an adder that drops a carry or an offset that gets lost.

// File: rtl/tree_xlate_pkg.sv
package tree_xlate_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ISSUE = 2'd1,
    WS_WAIT  = 2'd2,
    WS_DONE  = 2'd3
  } walk_st_e;

  localparam int ENTRY_W         = 32;
  localparam int ENTRY_VALID_BIT = 31;
  localparam int ENTRY_BYTES_LG2 = 2;
endpackage

// File: rtl/txw_rst_sync.sv
module txw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/txw_index_sel.sv
module txw_index_sel #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 4,
  parameter int LVL_W  = 1
) (
  input  logic [LEVELS*IDX_W-1:0] vpn,
  input  logic [LVL_W-1:0]        lvl,
  output logic [IDX_W-1:0]        idx
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  // level 0 takes the most significant field
  for (genvar j = 0; j < LEVELS; j++) begin : g_field
    assign idx_arr[j] = vpn[(LEVELS-1-j)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int j = 0; j < LEVELS; j++) begin
      if (lvl == LVL_W'(j)) idx = idx_arr[j];
    end
  end
endmodule

// File: rtl/txw_addr_gen.sv
module txw_addr_gen #(
  parameter int IDX_W = 4,
  parameter int OFF_W = 6,
  parameter int PA_W  = 16,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [IDX_W-1:0]   idx,
  output logic [PA_W-1:0]    addr
);
  import tree_xlate_pkg::*;

  logic [PA_W-1:0] page_base;
  logic [PA_W-1:0] entry_off;

  assign page_base = {frame, {OFF_W{1'b0}}};
  assign entry_off = PA_W'({idx, {ENTRY_BYTES_LG2{1'b0}}});
  assign addr      = page_base + entry_off;
endmodule

// File: rtl/txw_ctrl.sv
module txw_ctrl #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 6,
  parameter int PA_W   = 16,
  localparam int VA_W    = LEVELS*IDX_W + OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] dir_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic               mem_rd_ready,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data,
  output logic               mem_rd_valid,
  output logic [FRAME_W-1:0] cur_frame,
  output logic [LVL_W-1:0]   cur_lvl,
  output logic [VA_W-OFF_W-1:0] cur_vpn,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [LVL_W-1:0]   rsp_lvl,
  output logic [PA_W-1:0]    rsp_pa
);
  import tree_xlate_pkg::*;

  walk_st_e           st_q, st_d;
  logic [VA_W-1:0]    va_q, va_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic               fault_q, fault_d;
  logic [LVL_W-1:0]   flvl_q, flvl_d;
  logic [PA_W-1:0]    pa_q, pa_d;
  logic               va_en, frame_en, lvl_en, res_en;
  logic               ent_valid;
  logic [FRAME_W-1:0] ent_frame;
  logic               unused_ent_bits;

  assign ent_valid       = mem_rsp_data[ENTRY_VALID_BIT];
  assign ent_frame       = mem_rsp_data[FRAME_W-1:0];
  assign unused_ent_bits = ^mem_rsp_data[ENTRY_VALID_BIT-1:FRAME_W];

  always_comb begin
    st_d     = st_q;
    va_d     = va_q;
    frame_d  = frame_q;
    lvl_d    = lvl_q;
    fault_d  = fault_q;
    flvl_d   = flvl_q;
    pa_d     = pa_q;
    va_en    = 1'b0;
    frame_en = 1'b0;
    lvl_en   = 1'b0;
    res_en   = 1'b0;
    unique case (st_q)
      WS_IDLE: if (req_valid) begin
        va_d = req_va;  frame_d = dir_base;  lvl_d = '0;
        va_en = 1'b1;   frame_en = 1'b1;     lvl_en = 1'b1;
        st_d = WS_ISSUE;
      end
      WS_ISSUE: if (mem_rd_ready) st_d = WS_WAIT;
      WS_WAIT: if (mem_rsp_valid) begin
        if (!ent_valid) begin
          fault_d = 1'b1;  flvl_d = lvl_q;  pa_d = '0;
          res_en  = 1'b1;  st_d = WS_DONE;
        end else if (lvl_q == LVL_W'(LEVELS-1)) begin
          fault_d = 1'b0;  flvl_d = '0;  pa_d = {ent_frame, va_q[OFF_W-1:0]};
          res_en  = 1'b1;  st_d = WS_DONE;
        end else begin
          frame_d = ent_frame;  frame_en = 1'b1;
          lvl_d   = lvl_q + 1'b1;  lvl_en = 1'b1;
          st_d    = WS_ISSUE;
        end
      end
      WS_DONE: st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      va_q    <= '0;
      frame_q <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      pa_q    <= '0;
    end else begin
      st_q <= st_d;
      if (va_en)    va_q    <= va_d;
      if (frame_en) frame_q <= frame_d;
      if (lvl_en)   lvl_q   <= lvl_d;
      if (res_en) begin
        fault_q <= fault_d;
        flvl_q  <= flvl_d;
        pa_q    <= pa_d;
      end
    end
  end

  assign req_ready    = (st_q == WS_IDLE);
  assign mem_rd_valid = (st_q == WS_ISSUE);
  assign rsp_valid    = (st_q == WS_DONE);
  assign cur_frame    = frame_q;
  assign cur_lvl      = lvl_q;
  assign cur_vpn      = va_q[VA_W-1:OFF_W];
  assign rsp_fault    = fault_q;
  assign rsp_lvl      = flvl_q;
  assign rsp_pa       = pa_q;
endmodule

// File: rtl/tree_xlate_walker.sv
module tree_xlate_walker #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 6,
  parameter int PA_W   = 16,
  localparam int VA_W    = LEVELS*IDX_W + OFF_W,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] dir_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [LVL_W-1:0]   rsp_lvl,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_data
);
  logic                     rst_n_s;
  logic [FRAME_W-1:0]       cur_frame;
  logic [LVL_W-1:0]         cur_lvl;
  logic [LEVELS*IDX_W-1:0]  cur_vpn;
  logic [IDX_W-1:0]         cur_idx;

  txw_rst_sync rst_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  txw_ctrl #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n_s), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rd_valid(mem_rd_valid),
    .cur_frame(cur_frame), .cur_lvl(cur_lvl), .cur_vpn(cur_vpn),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_lvl(rsp_lvl), .rsp_pa(rsp_pa)
  );

  txw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W)) isel_i (
    .vpn(cur_vpn), .lvl(cur_lvl), .idx(cur_idx)
  );

  txw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) agen_i (
    .frame(cur_frame), .idx(cur_idx), .addr(mem_rd_addr)
  );
endmodule

// File: rtl/tree_xlate_walker_chk.sv
module tree_xlate_walker_chk #(
  parameter int LEVELS = 2,
  parameter int PA_W   = 16,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_rsp_valid,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [LVL_W-1:0] rsp_lvl,
  input logic [PA_W-1:0]  rsp_pa
);
  int   reads_q;
  logic outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reads_q <= 0;
      outst_q <= 1'b0;
    end else begin
      if (req_valid && req_ready)          reads_q <= 0;
      else if (mem_rd_valid && mem_rd_ready) reads_q <= reads_q + 1;
      if (mem_rd_valid && mem_rd_ready)    outst_q <= 1'b1;
      else if (mem_rsp_valid)              outst_q <= 1'b0;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> req_ready && !rsp_valid && !mem_rd_valid);

  p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

  p_fault_no_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && int'(rsp_lvl) < LEVELS);

  p_reads_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> reads_q == LEVELS);

  p_reads_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> reads_q == int'(rsp_lvl) + 1);

  p_single_outst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_rd_valid);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid) |-> !req_ready);
endmodule

bind tree_xlate_walker tree_xlate_walker_chk #(.LEVELS(LEVELS), .PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_lvl(rsp_lvl), .rsp_pa(rsp_pa)
);

// File: tb/tree_xlate_walker_tb_top.sv
`timescale 1ns/1ps
module tree_xlate_walker_tb_top;
  localparam int LEVELS = 2, IDX_W = 4, OFF_W = 6, PA_W = 16;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int VA_W = LEVELS*IDX_W + OFF_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic [FRAME_W-1:0] dir_base;
  logic               req_valid, req_ready;
  logic [VA_W-1:0]    req_va;
  logic               rsp_valid, rsp_fault;
  logic [0:0]         rsp_lvl;
  logic [PA_W-1:0]    rsp_pa;
  logic               mem_rd_valid, mem_rd_ready;
  logic [PA_W-1:0]    mem_rd_addr;
  logic               mem_rsp_valid;
  logic [31:0]        mem_rsp_data;

  int checks = 0, errors = 0, cycles = 0;

  tree_xlate_walker #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_va(req_va), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_lvl(rsp_lvl), .rsp_pa(rsp_pa),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // ---------------- memory model ----------------
  logic [31:0]     mem [int];
  logic [PA_W-1:0] rdq [$];
  logic            pend;
  logic [1:0]      lat;
  logic [PA_W-1:0] addr_q;

  function automatic logic [31:0] rd_word(input logic [PA_W-1:0] a);
    if (mem.exists(int'(a >> 2))) return mem[int'(a >> 2)];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rd_ready <= 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (lat == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd_word(addr_q);
          pend <= 1'b0;
        end else lat <= lat - 2'd1;
      end else if (mem_rd_valid && mem_rd_ready) begin
        pend   <= 1'b1;
        addr_q <= mem_rd_addr;
        lat    <= 2'($urandom_range(0, 2));
        rdq.push_back(mem_rd_addr);
      end
      mem_rd_ready <= ($urandom_range(0, 3) != 0);
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] ent_addr(input logic [FRAME_W-1:0] f,
                                               input logic [IDX_W-1:0] i);
    return PA_W'(f) * PA_W'(1 << OFF_W) + PA_W'(i) * PA_W'(4);
  endfunction

  function automatic logic [IDX_W-1:0] va_idx(input logic [VA_W-1:0] va, input int j);
    return IDX_W'(va >> (OFF_W + (LEVELS-1-j)*IDX_W));
  endfunction

  // entry: bit31 valid, [FRAME_W-1:0] frame, middle bits are filler (R4)
  task automatic put_entry(input logic [PA_W-1:0] a, input bit v,
                           input logic [FRAME_W-1:0] f, input logic [20:0] fill);
    mem[int'(a >> 2)] = {v, fill, f};
  endtask

  task automatic build(input logic [VA_W-1:0] va, input logic [FRAME_W-1:0] df,
                       input bit v0, input logic [FRAME_W-1:0] f1,
                       input bit v1, input logic [FRAME_W-1:0] f2,
                       input logic [20:0] fill);
    put_entry(ent_addr(df, va_idx(va, 0)), v0, f1, fill);
    put_entry(ent_addr(f1, va_idx(va, 1)), v1, f2, fill);
  endtask

  task automatic run_xlate(input logic [VA_W-1:0] va, input logic [FRAME_W-1:0] df,
                           input string tag);
    logic [PA_W-1:0]    ea [$];
    logic [FRAME_W-1:0] f;
    logic [31:0]        e;
    bit                 xf;
    int                 xl, n;
    bit                 busy_ok;
    logic [PA_W-1:0]    xpa;
    // expected walk (R2, R3, R10)
    f = df; xf = 1'b0; xl = 0; xpa = '0;
    for (int j = 0; j < LEVELS; j++) begin
      ea.push_back(ent_addr(f, va_idx(va, j)));
      e = rd_word(ea[j]);
      if (!e[31]) begin xf = 1'b1; xl = j; break; end
      f = e[FRAME_W-1:0];
    end
    if (!xf) xpa = {f, va[OFF_W-1:0]};
    rdq.delete();
    @(negedge clk);
    req_va = va; dir_base = df; req_valid = 1'b1;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_va = VA_W'($urandom);
    dir_base = FRAME_W'($urandom);
    busy_ok = 1'b1; n = 0;
    while (!rsp_valid && n < 200) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk); n++;
    end
    chk(n < 200, "R9", {tag, " response timeout"}, n, 200);
    chk(busy_ok, "R9", {tag, " req_ready low while busy"}, busy_ok, 1);
    chk(rsp_fault == xf, "R6", {tag, " fault flag"}, rsp_fault, xf);
    if (xf) begin
      chk(rsp_lvl == 1'(xl), "R6", {tag, " fault level"}, rsp_lvl, xl);
      chk(rsp_pa == '0, "R6", {tag, " pa on fault"}, rsp_pa, 0);
    end else begin
      chk(rsp_pa == xpa, "R5", {tag, " physical address"}, rsp_pa, xpa);
    end
    chk(rdq.size() == ea.size(), "R7", {tag, " read count"}, rdq.size(), ea.size());
    for (int j = 0; j < ea.size() && j < rdq.size(); j++)
      chk(rdq[j] == ea[j], (j == 0) ? "R2" : "R3", {tag, " read address"}, rdq[j], ea[j]);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", {tag, " pulse ends"}, {rsp_valid, req_ready}, 2'b01);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [VA_W-1:0]    va;
    logic [FRAME_W-1:0] df, f1, f2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; dir_base = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R1", "idle in reset",
        {req_ready, rsp_valid, mem_rd_valid}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R1", "idle after reset",
        {req_ready, rsp_valid, mem_rd_valid}, 3'b100);

    // R5/R10: all-ones indices and offset
    build(14'h3FFF, 10'h012, 1'b1, 10'h155, 1'b1, 10'h2A7, 21'h0);
    run_xlate(14'h3FFF, 10'h012, "r5_max_idx");
    // R10: zero address, table at frame 0
    build(14'h0000, 10'h000, 1'b1, 10'h3FF, 1'b1, 10'h001, 21'h0);
    run_xlate(14'h0000, 10'h000, "r10_zero");
    // R10: distinct index fields
    build(14'h2A5C, 10'h040, 1'b1, 10'h080, 1'b1, 10'h0C3, 21'h0);
    run_xlate(14'h2A5C, 10'h040, "r10_split");
    // R6: directory entry invalid
    build(14'h1234, 10'h100, 1'b0, 10'h200, 1'b1, 10'h300, 21'h0);
    run_xlate(14'h1234, 10'h100, "r6_dir_fault");
    // R6: leaf entry invalid
    build(14'h0987, 10'h101, 1'b1, 10'h201, 1'b0, 10'h301, 21'h0);
    run_xlate(14'h0987, 10'h101, "r6_leaf_fault");
    // R4: filler bits all ones must not leak into address or frame
    build(14'h3C41, 10'h3FF, 1'b1, 10'h000, 1'b1, 10'h3FF, 21'h1FFFFF);
    run_xlate(14'h3C41, 10'h3FF, "r4_filler");
    // R4: invalid entry whose other bits are all ones
    build(14'h1111, 10'h222, 1'b0, 10'h3FF, 1'b1, 10'h3FF, 21'h1FFFFF);
    run_xlate(14'h1111, 10'h222, "r4_invalid_filler");

    // random sparse trees (R2, R3, R5, R6, R7, R8)
    for (int k = 0; k < 80; k++) begin
      va = VA_W'($urandom);
      df = FRAME_W'($urandom);
      f1 = FRAME_W'($urandom);
      f2 = FRAME_W'($urandom);
      build(va, df, ($urandom_range(0, 7) != 0), f1,
            ($urandom_range(0, 7) != 0), f2, 21'($urandom));
      run_xlate(va, df, "rnd_walk");
    end
    // unmapped addresses: untouched memory reads as invalid (R6)
    for (int k = 0; k < 5; k++) begin
      run_xlate(VA_W'($urandom), FRAME_W'(10'h3F0 + k), "r6_unmapped");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule